// File: doc/BRIEF.md
# SHA-512 Message Schedule Generator

This block expands one 1024-bit message block into the eighty 64-bit words that feed the eighty rounds of the SHA-512 compression function. It produces one word per enabled clock, so it runs in step with a round engine that takes one round per cycle. The round engine asks for the next word with a step enable and reads the current word together with its round index.

A load strobe captures the whole block at once. The block is treated as sixteen 64-bit words, and the most significant 64 bits are word 0. Only the sixteen most recent words are kept. Each step computes one new word from four entries of that window, shifts the window by one place and writes the new word into the newest slot. After a load the first sixteen outputs are the block words in order, and every later output comes from the expansion rule. When the index reaches 79 the generator holds its output until the next load.

Top module: `msg_sched512`

## Requirements
- R1: After reset `wordValid` is 0, `roundIdx` is 0 and `wordOut` is 0.
- R2: In the cycle after `loadBlk` is sampled high, `wordValid` is 1 and `roundIdx` is 0.
- R3: After a load, word k for k = 0..15 equals `blockIn[1023-64k -: 64]`. Word 0 is the most significant 64 bits of the block.
- R4: For t = 16..79, word t = s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16] modulo 2^64. Here s0(x) = ror(x,1) ^ ror(x,8) ^ (x >> 7) and s1(x) = ror(x,19) ^ ror(x,61) ^ (x >> 6), where `>>` is a logical shift that fills with zeros.
- R5: While `wordValid` is 1 and `roundIdx` < 79, a cycle with `stepEn` high advances `roundIdx` by exactly 1 and presents the next word. A cycle with `stepEn` low leaves `roundIdx`, `wordOut` and `wordValid` unchanged.
- R6: When `roundIdx` is 79, `stepEn` has no effect: `roundIdx` stays 79 and `wordOut` keeps W79 until the next load.
- R7: A load restarts the sequence at index 0 with the new block's word 0, even in the middle of a block and even when `stepEn` is high in the same cycle.
- R8: While `wordValid` is 0 and no load occurs, `stepEn` has no effect and `wordValid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadBlk | input | 1 | Capture `blockIn` and restart at round 0 |
| blockIn | input | 1024 | Message block; bits 1023:960 form word 0 |
| stepEn | input | 1 | Advance to the next schedule word |
| wordOut | output | 64 | Schedule word for the current round |
| roundIdx | output | 7 | Index of the word on `wordOut` (0..79) |
| wordValid | output | 1 | A block is loaded and `wordOut` holds a valid word |

## Verification
The bound checker tests the sequencing rules on every cycle: restart after a load, with word 0 taken from the top of the captured block; a single-step advance of the index; holding when no step is requested; freezing at index 79; and staying idle before the first load. It does not check the data path of the expansion. Only the directed scenarios can show that W16..W79 follow the recurrence. They compare all eighty words of several blocks against an independent model, and they also cover restarts in the middle of a block and stalled steps.

// File: rtl/msg_sched_pkg.sv
package msg_sched_pkg;

  // Default geometry of the schedule.
  localparam int SCHED_WORD_W  = 64;
  localparam int SCHED_WIN     = 16;
  localparam int SCHED_ROUNDS  = 80;

  // Rotate / shift amounts of the two mixing functions.
  localparam int LO_ROT_A = 1;
  localparam int LO_ROT_B = 8;
  localparam int LO_SHR   = 7;
  localparam int HI_ROT_A = 19;
  localparam int HI_ROT_B = 61;
  localparam int HI_SHR   = 6;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadWin;
    logic shiftWin;
  } ctlStrobe_t;

endpackage

// File: rtl/msg_sched_ctrl.sv
module msg_sched_ctrl
  import msg_sched_pkg::*;
#(
  parameter int NUM_ROUNDS = SCHED_ROUNDS,
  localparam int IDX_W     = $clog2(NUM_ROUNDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadBlk,
  input  logic             stepEn,
  output ctlStrobe_t       strobes,
  output logic [IDX_W-1:0] roundIdx,
  output logic             wordValid
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ROUNDS - 1);

  logic [IDX_W-1:0] idxQ;
  logic             validQ;
  logic             atEnd;
  logic             advance;

  assign atEnd   = (idxQ == LAST_IDX);
  assign advance = stepEn && validQ && !loadBlk && !atEnd;

  always_comb begin
    strobes          = '0;
    strobes.loadWin  = loadBlk;
    strobes.shiftWin = advance;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ   <= '0;
      validQ <= 1'b0;
    end else if (loadBlk) begin
      idxQ   <= '0;
      validQ <= 1'b1;
    end else if (advance) begin
      idxQ   <= idxQ + IDX_W'(1);
    end
  end

  assign roundIdx  = idxQ;
  assign wordValid = validQ;

endmodule

// File: rtl/msg_sched_dp.sv
module msg_sched_dp
  import msg_sched_pkg::*;
#(
  parameter int WORD_W   = SCHED_WORD_W,
  parameter int WIN_DEPTH = SCHED_WIN,
  parameter int S0_RA    = LO_ROT_A,
  parameter int S0_RB    = LO_ROT_B,
  parameter int S0_SH    = LO_SHR,
  parameter int S1_RA    = HI_ROT_A,
  parameter int S1_RB    = HI_ROT_B,
  parameter int S1_SH    = HI_SHR,
  localparam int BLOCK_W = WORD_W * WIN_DEPTH,
  // Window taps relative to the oldest slot (slot 0 holds W[t]).
  localparam int TAP_OLD = 0,
  localparam int TAP_LO  = 1,
  localparam int TAP_MID = WIN_DEPTH - 7,
  localparam int TAP_HI  = WIN_DEPTH - 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobes,
  input  logic [BLOCK_W-1:0] blockIn,
  output logic [WORD_W-1:0]  wordOut
);

  function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] mixLo(input logic [WORD_W-1:0] x);
    return rotr(x, S0_RA) ^ rotr(x, S0_RB) ^ (x >> S0_SH);
  endfunction

  function automatic logic [WORD_W-1:0] mixHi(input logic [WORD_W-1:0] x);
    return rotr(x, S1_RA) ^ rotr(x, S1_RB) ^ (x >> S1_SH);
  endfunction

  logic [WORD_W-1:0] win [WIN_DEPTH];
  logic [WORD_W-1:0] nextWord;
  logic [WORD_W-1:0] sumA;
  logic [WORD_W-1:0] sumB;

  // Two parallel adds then a final add: three adders, depth two.
  assign sumA     = mixHi(win[TAP_HI]) + win[TAP_MID];
  assign sumB     = mixLo(win[TAP_LO]) + win[TAP_OLD];
  assign nextWord = sumA + sumB;

  for (genvar i = 0; i < WIN_DEPTH; i++) begin : g_slot
    logic [WORD_W-1:0] shiftIn;
    if (i == WIN_DEPTH - 1) begin : g_newest
      assign shiftIn = nextWord;
    end else begin : g_inner
      assign shiftIn = win[i+1];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        win[i] <= '0;
      end else if (strobes.loadWin) begin
        win[i] <= blockIn[BLOCK_W-1-i*WORD_W -: WORD_W];
      end else if (strobes.shiftWin) begin
        win[i] <= shiftIn;
      end
    end
  end

  assign wordOut = win[0];

endmodule

// File: rtl/msg_sched512.sv
module msg_sched512
  import msg_sched_pkg::*;
#(
  parameter int WORD_W     = SCHED_WORD_W,
  parameter int WIN_DEPTH  = SCHED_WIN,
  parameter int NUM_ROUNDS = SCHED_ROUNDS,
  localparam int BLOCK_W   = WORD_W * WIN_DEPTH,
  localparam int IDX_W     = $clog2(NUM_ROUNDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadBlk,
  input  logic [BLOCK_W-1:0] blockIn,
  input  logic               stepEn,
  output logic [WORD_W-1:0]  wordOut,
  output logic [IDX_W-1:0]   roundIdx,
  output logic               wordValid
);

  ctlStrobe_t strobes;

  msg_sched_ctrl #(
    .NUM_ROUNDS(NUM_ROUNDS)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .loadBlk  (loadBlk),
    .stepEn   (stepEn),
    .strobes  (strobes),
    .roundIdx (roundIdx),
    .wordValid(wordValid)
  );

  msg_sched_dp #(
    .WORD_W   (WORD_W),
    .WIN_DEPTH(WIN_DEPTH)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .blockIn(blockIn),
    .wordOut(wordOut)
  );

endmodule

// File: rtl/msg_sched512_chk.sv
module msg_sched512_chk #(
  parameter int WORD_W     = 64,
  parameter int WIN_DEPTH  = 16,
  parameter int NUM_ROUNDS = 80,
  localparam int BLOCK_W   = WORD_W * WIN_DEPTH,
  localparam int IDX_W     = $clog2(NUM_ROUNDS)
) (
  input logic               clk,
  input logic               rstN,
  input logic               loadBlk,
  input logic [BLOCK_W-1:0] blockIn,
  input logic               stepEn,
  input logic [WORD_W-1:0]  wordOut,
  input logic [IDX_W-1:0]   roundIdx,
  input logic               wordValid
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ROUNDS - 1);

  p_load_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadBlk |=> (wordValid && roundIdx == '0));

  p_load_word0_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadBlk |=> (wordOut == $past(blockIn[BLOCK_W-1 -: WORD_W])));

  p_step_inc_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && stepEn && !loadBlk && roundIdx != LAST_IDX)
      |=> (roundIdx == $past(roundIdx) + IDX_W'(1)));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!stepEn && !loadBlk)
      |=> ($stable(roundIdx) && $stable(wordOut) && $stable(wordValid)));

  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (roundIdx <= LAST_IDX));

  p_end_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && roundIdx == LAST_IDX && !loadBlk)
      |=> (roundIdx == LAST_IDX && $stable(wordOut)));

  p_unloaded_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!wordValid && !loadBlk) |=> !wordValid);

endmodule

bind msg_sched512 msg_sched512_chk #(
  .WORD_W    (WORD_W),
  .WIN_DEPTH (WIN_DEPTH),
  .NUM_ROUNDS(NUM_ROUNDS)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .loadBlk  (loadBlk),
  .blockIn  (blockIn),
  .stepEn   (stepEn),
  .wordOut  (wordOut),
  .roundIdx (roundIdx),
  .wordValid(wordValid)
);

// File: tb/msg_sched512_tb_top.sv
`timescale 1ns/1ps
module msg_sched512_tb_top;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadBlk = 1'b0;
  logic [1023:0] blockIn = '0;
  logic          stepEn = 1'b0;
  logic [63:0]   wordOut;
  logic [6:0]    roundIdx;
  logic          wordValid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit doneFlag = 1'b0;

  logic [63:0] refW [80];

  always #2 clk = ~clk;

  msg_sched512 dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .loadBlk  (loadBlk),
    .blockIn  (blockIn),
    .stepEn   (stepEn),
    .wordOut  (wordOut),
    .roundIdx (roundIdx),
    .wordValid(wordValid)
  );

  // ---------------- reference model (from R3/R4) ----------------
  function automatic logic [63:0] ror64(input logic [63:0] x, input int n);
    logic [127:0] d;
    d = {x, x} >> n;
    return d[63:0];
  endfunction

  function automatic logic [63:0] s0f(input logic [63:0] x);
    return ror64(x, 1) ^ ror64(x, 8) ^ (x >> 7);
  endfunction

  function automatic logic [63:0] s1f(input logic [63:0] x);
    return ror64(x, 19) ^ ror64(x, 61) ^ (x >> 6);
  endfunction

  task automatic buildRef(input logic [1023:0] blk);
    for (int k = 0; k < 16; k++) refW[k] = blk[1023-64*k -: 64];
    for (int t = 16; t < 80; t++)
      refW[t] = s1f(refW[t-2]) + refW[t-7] + s0f(refW[t-15]) + refW[t-16];
  endtask

  function automatic logic [1023:0] makeBlock(input logic [63:0] seed);
    logic [1023:0] b;
    logic [63:0] w;
    w = seed;
    for (int k = 0; k < 16; k++) begin
      w = w ^ (w << 13);
      w = w ^ (w >> 7);
      w = w ^ (w << 17);
      b[1023-64*k -: 64] = w;
    end
    return b;
  endfunction

  // ---------------- check helpers ----------------
  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  // ---------------- drive helpers (inputs change at negedge) ----------------
  task automatic doLoad(input logic [1023:0] blk, input logic withStep);
    blockIn = blk;
    loadBlk = 1'b1;
    stepEn  = withStep;
    @(negedge clk);
    loadBlk = 1'b0;
    stepEn  = 1'b0;
  endtask

  task automatic doStep();
    stepEn = 1'b1;
    @(negedge clk);
    stepEn = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic tResetState();
    chk("R1", "wordValid", 64'(wordValid), 64'd0);
    chk("R1", "roundIdx", 64'(roundIdx), 64'd0);
    chk("R1", "wordOut", wordOut, 64'd0);
  endtask

  task automatic tStepBeforeLoad();
    for (int i = 0; i < 4; i++) doStep();
    chk("R8", "wordValid after early steps", 64'(wordValid), 64'd0);
    chk("R8", "roundIdx after early steps", 64'(roundIdx), 64'd0);
    chk("R8", "wordOut after early steps", wordOut, 64'd0);
  endtask

  task automatic tFullBlock(input logic [1023:0] blk);
    buildRef(blk);
    doLoad(blk, 1'b0);
    chk("R2", "wordValid after load", 64'(wordValid), 64'd1);
    for (int t = 0; t < 80; t++) begin
      chk("R5", "roundIdx", 64'(roundIdx), 64'(t));
      if (t < 16) chk("R3", $sformatf("block word %0d", t), wordOut, refW[t]);
      else        chk("R4", $sformatf("expanded word %0d", t), wordOut, refW[t]);
      if (t < 79) doStep();
    end
    // R6: steps past the end have no effect
    for (int i = 0; i < 3; i++) doStep();
    chk("R6", "roundIdx frozen", 64'(roundIdx), 64'd79);
    chk("R6", "word frozen", wordOut, refW[79]);
    chk("R6", "still valid", 64'(wordValid), 64'd1);
  endtask

  task automatic tStalls(input logic [1023:0] blk);
    buildRef(blk);
    doLoad(blk, 1'b0);
    for (int t = 0; t < 30; t++) begin
      repeat (t % 3) @(negedge clk);
      chk("R5", "roundIdx with stalls", 64'(roundIdx), 64'(t));
      chk("R5", "word with stalls", wordOut, refW[t]);
      doStep();
    end
  endtask

  task automatic tRestart(input logic [1023:0] blkA, input logic [1023:0] blkB);
    doLoad(blkA, 1'b0);
    for (int i = 0; i < 20; i++) doStep();
    buildRef(blkB);
    doLoad(blkB, 1'b1);
    chk("R7", "roundIdx after restart", 64'(roundIdx), 64'd0);
    chk("R7", "word0 after restart", wordOut, refW[0]);
    for (int t = 1; t < 80; t++) doStep();
    chk("R7", "W79 of second block", wordOut, refW[79]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tResetState();
    rstN = 1'b1;
    @(negedge clk);
    tStepBeforeLoad();
    tFullBlock('0);
    tFullBlock({1024{1'b1}});
    tFullBlock(makeBlock(64'h0123_4567_89AB_CDEF));
    tFullBlock(makeBlock(64'hDEAD_BEEF_0000_0001));
    tStalls(makeBlock(64'h5A5A_1234_0F0F_9999));
    tRestart(makeBlock(64'h1111_2222_3333_4444), makeBlock(64'h7777_0000_ABCD_0042));
    finishRun();
  end

endmodule